// File: doc/BRIEF.md
# Multichannel TDM Serial Port

A synchronous serial port that moves data words between a parallel register interface and a pair of serial data lines, one bit per serial clock, most significant bit first. A one-clock frame sync pulse starts a transfer. In single-word mode each sync carries exactly one word. In multichannel mode the sync starts a time-division-multiplexed frame of 24 or 32 back-to-back word slots, and per-slot masks select which slots the port transmits into and which slots it captures.

The datapath can compress 16-bit linear samples into 8-bit logarithmic codes on the way out and expand received codes back into left-justified 16-bit linear samples, using either of the two standard telephony companding laws (mu-law or A-law). With companding off, words of 3 to 16 bits are sent from the low bits of the transmit register. Received words are placed right-justified, and the upper bits are either zero-filled or sign-extended. Each direction raises its own one-cycle done pulse when a word in an enabled slot completes.

The block is clocked by the serial clock itself. Host logic writes the next transmit word during the slot before the one it belongs to, and it reads each received word, with its slot number, on the done pulse.

Top module: `tdm_serial_port`

## Requirements
- R1: The active word length is `cfg_word_len`, limited to the range 3..16: values below 3 act as 3 and values above 16 act as 16. Bits leave on `txd` most significant bit first, taken from bits [len-1:0] of the transmit word.
- R2: `cfg_comp` selects the companding mode: 0 = linear, 1 = mu-law, 2 = A-law, 3 = linear. Under mu-law or A-law every word is 8 bits and `cfg_word_len` has no effect.
- R3: mu-law transmit sends the standard 8-bit mu-law code of the sample: 14-bit magnitude, clipped at 8158, bias 33, 3-bit segment and 4-bit mantissa, with the whole code inverted. Receive expands a code into the standard 16-bit linear value.
- R4: A-law transmit sends the standard 8-bit A-law code of the 13-bit sample. The code has a sign bit (1 = non-negative), a 3-bit segment and a 4-bit mantissa, and is XORed with 0x55. Receive expands a code into the standard 16-bit linear value.
- R5: When `fsync` is sampled high at a rising clock edge, the clock period that follows carries bit 0 (the MSB) of slot 0 on `txd`. `rxd` is sampled for that bit at the next rising edge. A sync pulse restarts the framing at any point.
- R6: In multichannel mode (`cfg_multi`=1), slots follow one another without gaps. There are 24 slots per frame (`cfg_wide_frame`=0) or 32 slots (`cfg_wide_frame`=1). After the last slot the port is idle until the next sync. With `cfg_multi`=0, one word in slot 0 follows each sync.
- R7: In multichannel mode, a slot s with `tx_slot_en[s]`=0 keeps `tx_oe` low and `txd` at 0. A slot s with `rx_slot_en[s]`=0 captures nothing. Mask bits at or above the frame length have no effect. While the port is idle, `tx_oe` is low.
- R8: A linear received word of length L is right-justified in `rx_word`. Bits at L and above are zero when `cfg_sign_ext`=0 and copies of bit L-1 when `cfg_sign_ext`=1.
- R9: `rx_done` and `tx_done` each pulse high for one cycle, right after the rising edge that ends the last bit of a word in a slot enabled for that direction. `rx_word` and `rx_slot` hold the captured word and its slot number from that pulse onwards.
- R10: After reset, `tx_oe`, `txd`, `rx_done`, `tx_done`, `rx_word` and `rx_slot` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial bit clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| fsync | input | 1 | Frame sync, one clock wide |
| rxd | input | 1 | Serial receive data |
| txd | output | 1 | Serial transmit data |
| tx_oe | output | 1 | Transmit output enable (low = line released) |
| cfg_word_len | input | 5 | Linear word length in bits |
| cfg_comp | input | 2 | Companding mode select |
| cfg_multi | input | 1 | Multichannel frame mode |
| cfg_wide_frame | input | 1 | 32 slots per frame when high, 24 when low |
| cfg_sign_ext | input | 1 | Sign-extend short received words |
| tx_slot_en | input | 32 | Per-slot transmit enables |
| rx_slot_en | input | 32 | Per-slot receive enables |
| tx_buf_wr | input | 1 | Write strobe for the transmit word register |
| tx_buf_data | input | 16 | Transmit word |
| rx_word | output | 16 | Last received word |
| rx_slot | output | 5 | Slot number of the last received word |
| rx_done | output | 1 | Receive word complete pulse |
| tx_done | output | 1 | Transmit word complete pulse |

## Verification
Linear words are looped from `txd` back to `rxd` for every legal length, with a mix of zero, all-ones, alternating and scattered values, under both extension settings. This separates errors in bit order, length counting and upper-bit fill, and two out-of-range lengths show the limiting. Each companding law is tried with a stepped sweep across the whole 16-bit input range, comparing the serial code against the law computed from segment thresholds. All 256 codes of each law are then driven straight into `rxd`, so an error can be placed in the encoder or in the expander. Two full frames, one of 24 slots and one of 32, with irregular masks and slot-dependent data, show whether enables, slot numbering, idle after the frame and ignored high mask bits are handled correctly.

// File: rtl/tdm_pkg.sv
package tdm_pkg;
  localparam int SAMPLE_W = 16;  // linear sample and longest word
  localparam int MIN_WL   = 3;
  localparam int CODE_W   = 8;   // companded code width

  typedef enum logic [1:0] {
    CMP_LINEAR = 2'b00,
    CMP_ULAW   = 2'b01,
    CMP_ALAW   = 2'b10,
    CMP_RSVD   = 2'b11
  } cmp_mode_e;

  // mu-law: 14-bit magnitude, biased by 33, segment from leading one
  function automatic logic [7:0] ulaw_compress(input logic [15:0] lin);
    logic [13:0] s14;
    logic        neg;
    logic [13:0] mag;
    logic [12:0] biased;
    logic [2:0]  seg;
    logic [3:0]  mant;
    s14 = lin[15:2];
    neg = s14[13];
    mag = neg ? (~s14 + 14'd1) : s14;
    if (mag > 14'd8158) mag = 14'd8158;
    biased = 13'(mag + 14'd33);
    seg = 3'd0;
    for (int i = 0; i < 8; i++)
      if (biased[i+5]) seg = 3'(i);
    mant = 4'(biased >> (seg + 4'd1));
    return ~{neg, seg, mant};
  endfunction

  function automatic logic [15:0] ulaw_expand(input logic [7:0] code);
    logic [7:0]  c;
    logic [15:0] t;
    c = ~code;
    t = (16'({c[3:0], 3'b000}) + 16'h0084) << c[6:4];
    t = t - 16'h0084;
    return c[7] ? (16'h0000 - t) : t;
  endfunction

  // A-law: 13-bit sample, one's-complement magnitude for negatives
  function automatic logic [7:0] alaw_compress(input logic [15:0] lin);
    logic [12:0] p;
    logic        neg;
    logic [12:0] mag;
    logic [2:0]  seg;
    logic [3:0]  mant;
    p   = lin[15:3];
    neg = p[12];
    mag = neg ? ~p : p;
    seg = 3'd0;
    for (int i = 1; i < 8; i++)
      if (mag[i+4]) seg = 3'(i);
    mant = (seg < 3'd2) ? mag[4:1] : 4'(mag >> seg);
    return {~neg, seg, mant} ^ 8'h55;
  endfunction

  function automatic logic [15:0] alaw_expand(input logic [7:0] code);
    logic [7:0]  a;
    logic [15:0] t;
    a = code ^ 8'h55;
    t = {8'h00, a[3:0], 4'h0};
    if (a[6:4] == 3'd0) t = t + 16'h0008;
    else                t = (t + 16'h0108) << (a[6:4] - 3'd1);
    return a[7] ? t : (16'h0000 - t);
  endfunction
endpackage

// File: rtl/tdm_frame_ctrl.sv
module tdm_frame_ctrl
  import tdm_pkg::*;
#(
  parameter  int SLOTS_A = 24,
  parameter  int SLOTS_B = 32,
  localparam int SLOT_W  = $clog2(SLOTS_B),
  localparam int BIT_W   = $clog2(SAMPLE_W),
  localparam int LEN_W   = $clog2(SAMPLE_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fsync,
  input  logic              multi,
  input  logic              wide_frame,
  input  logic [LEN_W-1:0]  wl_eff,
  output logic              active,
  output logic [BIT_W-1:0]  bit_idx,
  output logic [SLOT_W-1:0] slot,
  output logic              last_bit,
  output logic              slot_start,
  output logic [SLOT_W-1:0] next_slot
);
  logic              active_q;
  logic [BIT_W-1:0]  bit_q;
  logic [SLOT_W-1:0] slot_q;
  logic [SLOT_W-1:0] final_slot;
  logic              frame_end;

  assign final_slot = wide_frame ? SLOT_W'(SLOTS_B - 1) : SLOT_W'(SLOTS_A - 1);
  assign last_bit   = active_q && (LEN_W'(bit_q) == wl_eff - LEN_W'(1));
  assign frame_end  = last_bit && (!multi || slot_q == final_slot);
  assign slot_start = fsync || (last_bit && !frame_end);
  assign next_slot  = fsync ? '0 : slot_q + SLOT_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      bit_q    <= '0;
      slot_q   <= '0;
    end else if (fsync) begin
      active_q <= 1'b1;
      bit_q    <= '0;
      slot_q   <= '0;
    end else if (last_bit) begin
      bit_q <= '0;
      if (frame_end) active_q <= 1'b0;
      else           slot_q   <= slot_q + SLOT_W'(1);
    end else if (active_q) begin
      bit_q <= bit_q + BIT_W'(1);
    end
  end

  assign active  = active_q;
  assign bit_idx = bit_q;
  assign slot    = slot_q;

  AST_BIT_IN_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    active_q |-> (LEN_W'(bit_q) < wl_eff)); // R1
  AST_SLOT_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    active_q |-> (slot_q <= final_slot)); // R6
  AST_SINGLE_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && !multi) |-> (slot_q == '0)); // R6
  AST_FS_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    fsync |=> (active_q && bit_q == '0 && slot_q == '0)); // R5
endmodule

// File: rtl/tdm_tx_path.sv
module tdm_tx_path
  import tdm_pkg::*;
#(
  localparam int BIT_W = $clog2(SAMPLE_W),
  localparam int LEN_W = $clog2(SAMPLE_W + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                active,
  input  logic                slot_start,
  input  logic                en_next,
  input  logic                last_bit,
  input  logic [BIT_W-1:0]    bit_idx,
  input  logic [LEN_W-1:0]    wl_eff,
  input  cmp_mode_e           mode,
  input  logic [SAMPLE_W-1:0] buf_word,
  output logic                txd,
  output logic                tx_oe,
  output logic                tx_done
);
  logic [SAMPLE_W-1:0] cur_q;
  logic                on_q;
  logic                done_q;
  logic [SAMPLE_W-1:0] encoded;
  logic [LEN_W-1:0]    sel;

  always_comb begin
    case (mode)
      CMP_ULAW: encoded = SAMPLE_W'(ulaw_compress(buf_word));
      CMP_ALAW: encoded = SAMPLE_W'(alaw_compress(buf_word));
      default:  encoded = buf_word;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q  <= '0;
      on_q   <= 1'b0;
      done_q <= 1'b0;
    end else begin
      if (slot_start) begin
        cur_q <= encoded;
        on_q  <= en_next;
      end
      done_q <= last_bit && on_q;
    end
  end

  assign sel     = wl_eff - LEN_W'(1) - LEN_W'(bit_idx);
  assign tx_oe   = active && on_q;
  assign txd     = tx_oe ? cur_q[sel[BIT_W-1:0]] : 1'b0;
  assign tx_done = done_q;

  AST_TX_DONE_AFTER_OE: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done |-> $past(tx_oe)); // R9
endmodule

// File: rtl/tdm_rx_path.sv
module tdm_rx_path
  import tdm_pkg::*;
#(
  parameter  int SLOT_W = 5,
  localparam int LEN_W  = $clog2(SAMPLE_W + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                rxd,
  input  logic                active,
  input  logic                slot_start,
  input  logic                en_next,
  input  logic                last_bit,
  input  logic [SLOT_W-1:0]   slot,
  input  logic [LEN_W-1:0]    wl_eff,
  input  cmp_mode_e           mode,
  input  logic                sign_ext,
  output logic [SAMPLE_W-1:0] rx_word,
  output logic [SLOT_W-1:0]   rx_slot,
  output logic                rx_done
);
  logic [SAMPLE_W-2:0] sh_q;
  logic                on_q;
  logic [SAMPLE_W-1:0] word_q;
  logic [SLOT_W-1:0]   slot_q;
  logic                done_q;
  logic [SAMPLE_W-1:0] assembled;
  logic [SAMPLE_W-1:0] formatted;
  logic                top_bit;

  assign assembled = {sh_q, rxd};
  assign top_bit   = assembled[wl_eff - LEN_W'(1)];

  always_comb begin
    case (mode)
      CMP_ULAW: formatted = ulaw_expand(assembled[CODE_W-1:0]);
      CMP_ALAW: formatted = alaw_expand(assembled[CODE_W-1:0]);
      default: begin
        for (int i = 0; i < SAMPLE_W; i++)
          formatted[i] = (i < int'(wl_eff)) ? assembled[i] : (sign_ext & top_bit);
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      on_q   <= 1'b0;
      word_q <= '0;
      slot_q <= '0;
      done_q <= 1'b0;
    end else begin
      if (slot_start) on_q <= en_next;
      if (active && on_q) sh_q <= assembled[SAMPLE_W-2:0];
      done_q <= last_bit && on_q;
      if (last_bit && on_q) begin
        word_q <= formatted;
        slot_q <= slot;
      end
    end
  end

  assign rx_word = word_q;
  assign rx_slot = slot_q;
  assign rx_done = done_q;

  AST_RX_DONE_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done |-> $past(last_bit)); // R9
endmodule

// File: rtl/tdm_serial_port.sv
module tdm_serial_port
  import tdm_pkg::*;
#(
  parameter  int SLOTS_A = 24,
  parameter  int SLOTS_B = 32,
  localparam int SLOT_W  = $clog2(SLOTS_B),
  localparam int BIT_W   = $clog2(SAMPLE_W),
  localparam int LEN_W   = $clog2(SAMPLE_W + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                fsync,
  input  logic                rxd,
  output logic                txd,
  output logic                tx_oe,
  input  logic [LEN_W-1:0]    cfg_word_len,
  input  logic [1:0]          cfg_comp,
  input  logic                cfg_multi,
  input  logic                cfg_wide_frame,
  input  logic                cfg_sign_ext,
  input  logic [SLOTS_B-1:0]  tx_slot_en,
  input  logic [SLOTS_B-1:0]  rx_slot_en,
  input  logic                tx_buf_wr,
  input  logic [SAMPLE_W-1:0] tx_buf_data,
  output logic [SAMPLE_W-1:0] rx_word,
  output logic [SLOT_W-1:0]   rx_slot,
  output logic                rx_done,
  output logic                tx_done
);
  cmp_mode_e           mode;
  logic [LEN_W-1:0]    wl_eff;
  logic [SAMPLE_W-1:0] tx_buf_q;
  logic                active, last_bit, slot_start;
  logic [BIT_W-1:0]    bit_idx;
  logic [SLOT_W-1:0]   slot, next_slot;
  logic                tx_en_next, rx_en_next;

  assign mode = cmp_mode_e'(cfg_comp);

  always_comb begin
    if (mode == CMP_ULAW || mode == CMP_ALAW) wl_eff = LEN_W'(CODE_W);
    else if (cfg_word_len < LEN_W'(MIN_WL))   wl_eff = LEN_W'(MIN_WL);
    else if (cfg_word_len > LEN_W'(SAMPLE_W)) wl_eff = LEN_W'(SAMPLE_W);
    else                                      wl_eff = cfg_word_len;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         tx_buf_q <= '0;
    else if (tx_buf_wr) tx_buf_q <= tx_buf_data;
  end

  assign tx_en_next = cfg_multi ? tx_slot_en[next_slot] : 1'b1;
  assign rx_en_next = cfg_multi ? rx_slot_en[next_slot] : 1'b1;

  tdm_frame_ctrl #(.SLOTS_A(SLOTS_A), .SLOTS_B(SLOTS_B)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .fsync(fsync), .multi(cfg_multi),
    .wide_frame(cfg_wide_frame), .wl_eff(wl_eff), .active(active),
    .bit_idx(bit_idx), .slot(slot), .last_bit(last_bit),
    .slot_start(slot_start), .next_slot(next_slot)
  );

  tdm_tx_path u_tx (
    .clk(clk), .rst_n(rst_n), .active(active), .slot_start(slot_start),
    .en_next(tx_en_next), .last_bit(last_bit), .bit_idx(bit_idx),
    .wl_eff(wl_eff), .mode(mode), .buf_word(tx_buf_q),
    .txd(txd), .tx_oe(tx_oe), .tx_done(tx_done)
  );

  tdm_rx_path #(.SLOT_W(SLOT_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .rxd(rxd), .active(active),
    .slot_start(slot_start), .en_next(rx_en_next), .last_bit(last_bit),
    .slot(slot), .wl_eff(wl_eff), .mode(mode), .sign_ext(cfg_sign_ext),
    .rx_word(rx_word), .rx_slot(rx_slot), .rx_done(rx_done)
  );

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!active) |-> (!tx_oe && !txd)); // R7
endmodule

// File: tb/tdm_serial_port_test.sv
`timescale 1ns/1ps
module tdm_serial_port_test;
  logic        clk = 1'b0;
  logic        rst_n, fsync, rxd_drv, loopback, rxd_pin;
  logic        txd, tx_oe, rx_done, tx_done;
  logic [4:0]  cfg_word_len, rx_slot;
  logic [1:0]  cfg_comp;
  logic        cfg_multi, cfg_wide_frame, cfg_sign_ext, tx_buf_wr;
  logic [31:0] tx_slot_en, rx_slot_en;
  logic [15:0] tx_buf_data, rx_word;
  int          nvec = 0, nfail = 0;

  always #2 clk = ~clk;

  assign rxd_pin = loopback ? (tx_oe ? txd : 1'b0) : rxd_drv;

  tdm_serial_port uut (
    .clk(clk), .rst_n(rst_n), .fsync(fsync), .rxd(rxd_pin), .txd(txd),
    .tx_oe(tx_oe), .cfg_word_len(cfg_word_len), .cfg_comp(cfg_comp),
    .cfg_multi(cfg_multi), .cfg_wide_frame(cfg_wide_frame),
    .cfg_sign_ext(cfg_sign_ext), .tx_slot_en(tx_slot_en),
    .rx_slot_en(rx_slot_en), .tx_buf_wr(tx_buf_wr), .tx_buf_data(tx_buf_data),
    .rx_word(rx_word), .rx_slot(rx_slot), .rx_done(rx_done), .tx_done(tx_done)
  );

  task automatic chk(input string req, input int got, input int expv);
    nvec++;
    if (got != expv) begin
      nfail++;
      $display("FAIL %s: got %0h expected %0h", req, got, expv);
    end
  endtask

  // companding laws restated with threshold searches
  function automatic int mu_enc(input int x);
    int v, m, seg, mant;
    v = x >>> 2;
    m = (v < 0) ? -v : v;
    if (m > 8158) m = 8158;
    m = m + 33;
    seg = 0;
    while (m >= (64 << seg)) seg++;
    mant = (m >> (seg + 1)) & 15;
    return ((seg << 4) | mant) ^ ((v < 0) ? 127 : 255);
  endfunction

  function automatic int mu_dec(input int c);
    int u, m;
    u = ~c & 255;
    m = ((((2 * (u & 15)) + 33) << ((u >> 4) & 7)) - 33) * 4;
    return ((u & 128) != 0) ? -m : m;
  endfunction

  function automatic int a_enc(input int x);
    int v, m, seg, mant;
    v = x >>> 3;
    m = (v < 0) ? (-v - 1) : v;
    seg = 0;
    while (seg < 7 && m >= (32 << seg)) seg++;
    mant = (seg < 2) ? ((m >> 1) & 15) : ((m >> seg) & 15);
    return (((v < 0) ? 0 : 128) | (seg << 4) | mant) ^ 85;
  endfunction

  function automatic int a_dec(input int c);
    int a, seg, m;
    a = c ^ 85;
    seg = (a >> 4) & 7;
    m = (seg == 0) ? 8 * (2 * (a & 15) + 1) : 8 * ((2 * (a & 15) + 33) << (seg - 1));
    return ((a & 128) != 0) ? m : -m;
  endfunction

  function automatic int slot_val(input int s);
    return (s * 7 + 3) & 65535;
  endfunction

  // one single-word transfer of n bits; returns the bits seen on txd
  task automatic xfer(input logic [15:0] txv, input logic [15:0] drv,
                      input int n, output int sent);
    @(negedge clk); tx_buf_wr = 1'b1; tx_buf_data = txv;
    @(negedge clk); tx_buf_wr = 1'b0; fsync = 1'b1;
    sent = 0;
    for (int b = 0; b < n; b++) begin
      @(negedge clk);
      fsync = 1'b0;
      sent = (sent << 1) | int'(txd);
      rxd_drv = drv[n - 1 - b];
    end
    @(negedge clk);
  endtask

  task automatic run_frame(input int ns, input logic [31:0] txm, input logic [31:0] rxm);
    int got [32];
    int seen [32];
    int tcnt, rcnt, expt, expr, total;
    tcnt = 0; rcnt = 0; expt = 0; expr = 0;
    for (int s = 0; s < 32; s++) begin got[s] = 0; seen[s] = 0; end
    cfg_multi = 1'b1; cfg_wide_frame = (ns == 32); cfg_word_len = 5'd5;
    cfg_comp = 2'd0; cfg_sign_ext = 1'b0; loopback = 1'b1;
    tx_slot_en = txm; rx_slot_en = rxm;
    @(negedge clk); tx_buf_wr = 1'b1; tx_buf_data = 16'(slot_val(0));
    @(negedge clk); tx_buf_wr = 1'b0; fsync = 1'b1;
    total = ns * 5;
    for (int i = 1; i <= total + 2; i++) begin
      @(negedge clk);
      fsync = 1'b0; tx_buf_wr = 1'b0;
      if (i <= total) begin
        int s, b;
        s = (i - 1) / 5; b = (i - 1) % 5;
        chk("R7 tx_oe follows slot enable", int'(tx_oe), int'(txm[s]));
        if (!txm[s]) chk("R7 txd quiet in disabled slot", int'(txd), 0);
        if (b == 0 && s + 1 < ns) begin
          tx_buf_wr = 1'b1; tx_buf_data = 16'(slot_val(s + 1));
        end
      end else begin
        chk("R6 idle after last slot", int'(tx_oe), 0);
      end
      if (rx_done) begin seen[rx_slot] = 1; got[rx_slot] = int'(rx_word); rcnt++; end
      if (tx_done) tcnt++;
    end
    for (int s = 0; s < 32; s++) begin
      int want;
      want = (s < ns && rxm[s]) ? 1 : 0;
      if (s < ns && txm[s]) expt++;
      expr += want;
      chk("R7 rx capture only in enabled slots", seen[s], want);
      if (want == 1)
        chk("R6 slot data by slot number", got[s], txm[s] ? (slot_val(s) & 31) : 0);
    end
    chk("R9 tx_done count per frame", tcnt, expt);
    chk("R9 rx_done count per frame", rcnt, expr);
    repeat (3) @(negedge clk);
  endtask

  initial begin : watchdog
    #(4 * 190000);
    nfail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin : main
    int sent, v, wl, expv, mask, code;
    rst_n = 1'b0; fsync = 1'b0; rxd_drv = 1'b0; loopback = 1'b1;
    cfg_word_len = 5'd8; cfg_comp = 2'd0; cfg_multi = 1'b0; cfg_wide_frame = 1'b0;
    cfg_sign_ext = 1'b0; tx_slot_en = '0; rx_slot_en = '0;
    tx_buf_wr = 1'b0; tx_buf_data = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 reset tx_oe", int'(tx_oe), 0);
    chk("R10 reset txd", int'(txd), 0);
    chk("R10 reset rx_done", int'(rx_done), 0);
    chk("R10 reset tx_done", int'(tx_done), 0);
    chk("R10 reset rx_word", int'(rx_word), 0);
    chk("R10 reset rx_slot", int'(rx_slot), 0);

    // linear loopback over every length, both fill modes
    for (int w = 3; w <= 16; w++) begin
      for (int se = 0; se < 2; se++) begin
        for (int k = 0; k < 10; k++) begin
          case (k)
            0: v = 0;
            1: v = 65535;
            2: v = 21845;
            3: v = 43690;
            default: v = (k * 40503 + w * 977 + se * 3) & 65535;
          endcase
          cfg_word_len = 5'(w); cfg_sign_ext = se[0];
          xfer(16'(v), 16'h0, w, sent);
          mask = (1 << w) - 1;
          expv = v & mask;
          if (se == 1 && ((v >> (w - 1)) & 1) == 1) expv = expv | (65535 & ~mask);
          chk("R1 serial bits MSB first", sent, v & mask);
          chk("R8 received justification", int'(rx_word), expv);
          chk("R9 rx_done pulse", int'(rx_done), 1);
          chk("R9 tx_done pulse", int'(tx_done), 1);
          chk("R6 single word uses slot 0", int'(rx_slot), 0);
          chk("R6 single word then idle", int'(tx_oe), 0);
          @(negedge clk);
          chk("R9 rx_done lasts one cycle", int'(rx_done), 0);
        end
      end
    end

    // length limiting
    cfg_sign_ext = 1'b0;
    cfg_word_len = 5'd1;
    xfer(16'h0006, 16'h0, 3, sent);
    chk("R1 short length acts as 3", sent, 6);
    chk("R1 short length receive", int'(rx_word), 6);
    cfg_word_len = 5'd20;
    xfer(16'hB38D, 16'h0, 16, sent);
    chk("R1 long length acts as 16", sent, 16'hB38D);
    chk("R1 long length receive", int'(rx_word), 16'hB38D);

    // reserved companding code behaves as linear
    cfg_comp = 2'd3; cfg_word_len = 5'd12;
    xfer(16'h0A5C, 16'h0, 12, sent);
    chk("R2 reserved mode is linear", sent, 16'h0A5C);
    chk("R2 reserved mode receive", int'(rx_word), 16'h0A5C);

    // companding sweeps, word length setting ignored
    for (int law = 1; law <= 2; law++) begin
      cfg_comp = 2'(law);
      for (int x = -32768; x < 32768 + 4 * 131; x += 131) begin
        int xv;
        xv = (x > 32767) ? 32767 : x;
        cfg_word_len = 5'((x & 7) + 9);
        xfer(16'(xv), 16'h0, 8, sent);
        code = (law == 1) ? mu_enc(xv) : a_enc(xv);
        expv = ((law == 1) ? mu_dec(code) : a_dec(code)) & 65535;
        if (law == 1) begin
          chk("R3 mu-law code on txd", sent, code);
          chk("R3 mu-law loopback value", int'(rx_word), expv);
        end else begin
          chk("R4 A-law code on txd", sent, code);
          chk("R4 A-law loopback value", int'(rx_word), expv);
        end
        chk("R2 eight-bit word when companding", int'(tx_done), 1);
      end
    end

    // every code driven directly into the receiver
    loopback = 1'b0;
    for (int law = 1; law <= 2; law++) begin
      cfg_comp = 2'(law);
      for (int c = 0; c < 256; c++) begin
        xfer(16'h0, 16'(c), 8, sent);
        if (law == 1) chk("R3 mu-law expansion", int'(rx_word), mu_dec(c) & 65535);
        else          chk("R4 A-law expansion", int'(rx_word), a_dec(c) & 65535);
      end
    end

    // multichannel frames (R5 slot 0 aligned to sync)
    run_frame(24, 32'hFF0A_5A5F, 32'hFF0F_0F33);
    run_frame(32, 32'hF00F_F0F1, 32'h8C3E_71A5);

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule